// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block is the control side of one DMA channel. It walks a list of fixed-size transfer elements that sit back to back in a descriptor memory. For each data element it issues exactly one copy command, carrying a source, a destination and a length. It then waits for the data mover to report that the copy has finished. Moving the data and arbitrating the bus are done elsewhere.

An element is valid only when the cycle bit in its control word equals the channel's expected cycle value. This lets software refill a region of descriptor memory while the engine runs:

- The walker stops quietly at the first element that software has not yet handed over.
- A link element sends fetching to a new position and can invert the expected value, so the same memory can be reused chunk by chunk.
- A zero length or a failed descriptor read aborts the channel.

Each element is six 32-bit words at increasing addresses: control, size, source low, source high, destination low, destination high.

Control word bits:

| Bit | Meaning |
|-----|---------|
| 0 | Cycle |
| 1 | Link |
| 2 | Invert expected cycle (link elements only) |
| 3 | Local interrupt enable |
| 4 | Remote interrupt enable |

Three interfaces use valid/ready:

- **Descriptor read request:** `mem_req_valid` stays high with `mem_req_addr` stable until `mem_req_ready`. One read is outstanding at a time, and its answer arrives as a one-cycle `mem_rsp_valid`.
- **Copy command:** `cmd_valid` stays high with the command fields stable until `cmd_ready`. The downstream side may hold `cmd_ready` low for any number of cycles.
- **Completion:** a one-cycle `cpl_valid`.

The doorbell and the status outputs are plain level or pulse pins.

Top module: `ll_desc_walker`

## Requirements
- R1: After reset the walker is idle, with `st_busy`, `cmd_valid`, `mem_req_valid`, `irq_done` and `irq_abort` low, `st_ptr` zero and `st_cycle` zero.
- R2: When idle, a `db_ring` pulse with `db_load` high sets the pointer to `db_ptr` (bits 1:0 forced to zero) and the expected cycle to `db_cycle`, then starts fetching. A pulse with `db_load` low resumes at the current pointer with the current expected cycle.
- R3: An element is fetched as six word reads at pointer+0, +4, … +20, in the word order control, size, source low, source high, destination low, destination high. A request is held with a stable address until accepted.
- R4: A data element (control bit 1 clear) whose control bit 0 equals the expected cycle produces one command with `cmd_src` = {word3, word2}, `cmd_dst` = {word5, word4} and `cmd_len` = word1. The command is held stable until `cmd_ready`.
- R5: Only one command is in flight. The next element is fetched only after `cpl_valid`, and the pointer then advances by 24 bytes.
- R6: Completing a data element whose control bit 3 or bit 4 is set raises `irq_done` for exactly one cycle. An element with both bits clear raises nothing.
- R7: An element whose cycle bit differs from the expected cycle is not executed. The walker goes idle with no command and no interrupt, and the pointer is left on that element. A later doorbell without load fetches it again.
- R8: A matching link element (control bit 1 set) issues no command. It moves the pointer to {word3, word2} (low two bits forced to zero), and it inverts the expected cycle when control bit 2 is set.
- R9: A matching data element with length zero issues no command. It raises `irq_abort` for one cycle and returns to idle with the pointer on that element.
- R10: A descriptor read answered with `mem_rsp_err` raises `irq_abort` for one cycle and returns to idle with the pointer on the element being fetched. Commands already completed remain valid.
- R11: A doorbell that arrives while the walker is busy has no effect on the pointer, on the expected cycle or on the command sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_ring | input | 1 | Doorbell pulse |
| db_load | input | 1 | With doorbell: load pointer and cycle |
| db_ptr | input | AW | Start pointer (byte address) |
| db_cycle | input | 1 | Start expected cycle value |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Descriptor read request accepted |
| mem_req_addr | output | AW | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data word |
| mem_rsp_err | input | 1 | Read failed |
| cmd_valid | output | 1 | Copy command valid |
| cmd_ready | input | 1 | Copy command accepted |
| cmd_src | output | 64 | Source byte address |
| cmd_dst | output | 64 | Destination byte address |
| cmd_len | output | 32 | Length in bytes (never zero) |
| cpl_valid | input | 1 | Copy finished (one cycle) |
| irq_done | output | 1 | Done interrupt pulse |
| irq_abort | output | 1 | Abort interrupt pulse |
| st_ptr | output | AW | Current element pointer |
| st_cycle | output | 1 | Expected cycle value |
| st_busy | output | 1 | Walker not idle |

## Verification
The bench targets four corner cases:

- **Stopping on a cycle mismatch and resuming.** A walker that skipped the stale element would emit a command from stale memory. One that advanced past it would refetch the wrong place on the next doorbell.
- **Link elements with and without cycle inversion.** Inverting unconditionally, or ignoring the invert flag, would make the element after the link either run or stall wrongly.
- **Both abort sources.** A zero length or a mid-element read error must leave the pointer on the faulty element and issue no command for it. A design that treated zero as a huge length would instead emit a command.
- **A doorbell that lands mid-run while both ready signals are throttled.** It would redirect a careless walker to the newly loaded pointer.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  localparam int unsigned DESC_WORDS = 6;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ELEM_BYTES = DESC_WORDS * (WORD_W / 8);

  // control word bit positions (software depends on these)
  localparam int unsigned CB_CYCLE     = 0;
  localparam int unsigned CB_LINK      = 1;
  localparam int unsigned CB_INVERT    = 2;
  localparam int unsigned CB_LOCAL_IE  = 3;
  localparam int unsigned CB_REMOTE_IE = 4;

  // word slots inside one element
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_SIZE   = 1;
  localparam int unsigned W_SRC_LO = 2;
  localparam int unsigned W_SRC_HI = 3;
  localparam int unsigned W_DST_LO = 4;
  localparam int unsigned W_DST_HI = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_ISSUE,
    ST_WAIT_DONE,
    ST_LINK,
    ST_ABORT
  } walk_state_e;

  typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words_t;

  typedef struct packed {
    logic        hit;
    logic        link;
    logic        invert;
    logic        notify;
    logic        len_zero;
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] len;
    logic [63:0] next_ptr;
  } desc_view_t;
endpackage

// File: rtl/ldw_fetch.sv
module ldw_fetch
  import ldw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  input  logic          rsp_err,
  output logic          done,
  output logic          err,
  output desc_words_t   words
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_e;

  fetch_state_e   fs;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]  base_q;

  assign req_valid = (fs == F_REQ);
  assign req_addr  = base_q + AW'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs     <= F_IDLE;
      idx    <= '0;
      base_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      words  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (fs)
        F_IDLE: begin
          if (go) begin
            idx    <= '0;
            base_q <= base;
            fs     <= F_REQ;
          end
        end
        F_REQ: begin
          if (req_ready) fs <= F_WAIT;
        end
        F_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err <= 1'b1;
              fs  <= F_IDLE;
            end else begin
              words[idx] <= rsp_data;
              if (idx == LAST_IDX) begin
                done <= 1'b1;
                fs   <= F_IDLE;
              end else begin
                idx <= idx + 1'b1;
                fs  <= F_REQ;
              end
            end
          end
        end
        default: fs <= F_IDLE;
      endcase
    end
  end

  // R3: a posted request keeps its address until taken
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R3: requests stay word aligned
  a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  // R3: done and error never in the same cycle
  a_r3_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

// File: rtl/ldw_decode.sv
module ldw_decode
  import ldw_pkg::*;
(
  input  desc_words_t words,
  input  logic        exp_cycle,
  output desc_view_t  view
);
  logic [WORD_W-1:0] ctrl;

  assign ctrl = words[W_CTRL];

  always_comb begin
    view.hit      = (ctrl[CB_CYCLE] == exp_cycle);
    view.link     = ctrl[CB_LINK];
    view.invert   = ctrl[CB_INVERT];
    view.notify   = ctrl[CB_LOCAL_IE] | ctrl[CB_REMOTE_IE];
    view.len      = words[W_SIZE];
    view.len_zero = (words[W_SIZE] == '0);
    view.src      = {words[W_SRC_HI], words[W_SRC_LO]};
    view.dst      = {words[W_DST_HI], words[W_DST_LO]};
    // a link element reuses the source slots for the jump target
    view.next_ptr = {words[W_SRC_HI], words[W_SRC_LO]};
  end
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
  import ldw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          db_ring,
  input  logic          db_load,
  input  logic [AW-1:0] db_ptr,
  input  logic          db_cycle,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [63:0]   cmd_src,
  output logic [63:0]   cmd_dst,
  output logic [31:0]   cmd_len,
  input  logic          cpl_valid,
  output logic          irq_done,
  output logic          irq_abort,
  output logic [AW-1:0] st_ptr,
  output logic          st_cycle,
  output logic          st_busy
);
  localparam logic [AW-1:0] STEP = AW'(ELEM_BYTES);

  walk_state_e   state, state_n;
  logic [AW-1:0] ptr, ptr_n;
  logic          cyc, cyc_n;
  logic          fetch_go, f_done, f_err;
  desc_words_t   words;
  desc_view_t    view;

  ldw_fetch #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (fetch_go),
    .base      (ptr_n),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .rsp_err   (mem_rsp_err),
    .done      (f_done),
    .err       (f_err),
    .words     (words)
  );

  ldw_decode u_decode (
    .words     (words),
    .exp_cycle (cyc),
    .view      (view)
  );

  always_comb begin
    state_n = state;
    ptr_n   = ptr;
    cyc_n   = cyc;
    case (state)
      ST_IDLE: begin
        if (db_ring) begin
          state_n = ST_FETCH;
          if (db_load) begin
            ptr_n = {db_ptr[AW-1:2], 2'b00};
            cyc_n = db_cycle;
          end
        end
      end
      ST_FETCH: begin
        if (f_err)       state_n = ST_ABORT;
        else if (f_done) state_n = ST_DECODE;
      end
      ST_DECODE: begin
        if (!view.hit)         state_n = ST_IDLE;
        else if (view.link)    state_n = ST_LINK;
        else if (view.len_zero) state_n = ST_ABORT;
        else                   state_n = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (cmd_ready) state_n = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (cpl_valid) begin
          ptr_n   = ptr + STEP;
          state_n = ST_FETCH;
        end
      end
      ST_LINK: begin
        ptr_n   = {view.next_ptr[AW-1:2], 2'b00};
        if (view.invert) cyc_n = ~cyc;
        state_n = ST_FETCH;
      end
      ST_ABORT: state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  assign fetch_go = (state_n == ST_FETCH) && (state != ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ptr      <= '0;
      cyc      <= 1'b0;
      irq_done <= 1'b0;
    end else begin
      state    <= state_n;
      ptr      <= ptr_n;
      cyc      <= cyc_n;
      irq_done <= (state == ST_WAIT_DONE) && cpl_valid && view.notify;
    end
  end

  assign cmd_valid = (state == ST_ISSUE);
  assign cmd_src   = view.src;
  assign cmd_dst   = view.dst;
  assign cmd_len   = view.len;
  assign irq_abort = (state == ST_ABORT);
  assign st_ptr    = ptr;
  assign st_cycle  = cyc;
  assign st_busy   = (state != ST_IDLE);

  // R4: a posted command is held unchanged until accepted
  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src)
      && $stable(cmd_dst) && $stable(cmd_len));

  // R9: a command never carries a zero length
  a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != '0);

  // R5: no descriptor read while a command is posted
  a_r5_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req_valid);

  // R6: done interrupt is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  // R10: abort interrupt is a single-cycle pulse and ends the run
  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |=> !irq_abort && !st_busy);

  // R2: the pointer is always word aligned
  a_r2_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    st_ptr[1:0] == 2'b00);

  // R11: a doorbell while busy leaves pointer and cycle alone
  a_r11_busy_ring: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy && db_ring && state == ST_FETCH && !f_done && !f_err
      |=> $stable(st_ptr) && $stable(st_cycle));
endmodule

// File: tb/ll_desc_walker_test.sv
module ll_desc_walker_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          db_ring, db_load, db_cycle;
  logic [AW-1:0] db_ptr;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid, mem_rsp_err;
  logic [31:0]   mem_rsp_data;
  logic          cmd_valid, cmd_ready;
  logic [63:0]   cmd_src, cmd_dst;
  logic [31:0]   cmd_len;
  logic          cpl_valid;
  logic          irq_done, irq_abort;
  logic [AW-1:0] st_ptr;
  logic          st_cycle, st_busy;

  always #2 clk = ~clk;

  ll_desc_walker #(.AW(AW)) uut (.*);

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [64];
  logic [AW-1:0] err_addr;
  logic          err_on;
  int unsigned   tick = 0;

  int          n_cmd, n_done, n_abort;
  logic [63:0] lg_src [16];
  logic [63:0] lg_dst [16];
  logic [31:0] lg_len [16];
  int          cd;

  // ready throttling, driven away from the active edge
  always @(negedge clk) begin
    tick++;
    cmd_ready     = (tick % 3) != 0;
    mem_req_ready = (tick % 4) != 1;
  end

  // descriptor memory: answers one cycle after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[7:2]];
    mem_rsp_err   <= mem_req_valid && mem_req_ready && err_on
                     && (mem_req_addr == err_addr);
  end

  // data mover stand-in: completes three cycles after acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      cd        <= 0;
      cpl_valid <= 1'b0;
    end else begin
      cpl_valid <= (cd == 1);
      if (cd != 0) cd <= cd - 1;
      if (cmd_valid && cmd_ready) begin
        if (n_cmd < 16) begin
          lg_src[n_cmd] <= cmd_src;
          lg_dst[n_cmd] <= cmd_dst;
          lg_len[n_cmd] <= cmd_len;
        end
        n_cmd <= n_cmd + 1;
        cd    <= 3;
      end
      if (irq_done)  n_done  <= n_done + 1;
      if (irq_abort) n_abort <= n_abort + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  task automatic put_data(input int base, input bit cyc, input bit lie,
                          input bit rie, input logic [31:0] len,
                          input logic [63:0] src, input logic [63:0] dst);
    int w;
    w = base / 4;
    mem[w]   = {27'd0, rie, lie, 1'b0, 1'b0, cyc};
    mem[w+1] = len;
    mem[w+2] = src[31:0];
    mem[w+3] = src[63:32];
    mem[w+4] = dst[31:0];
    mem[w+5] = dst[63:32];
  endtask

  task automatic put_link(input int base, input bit cyc, input bit inv,
                          input logic [63:0] target);
    int w;
    w = base / 4;
    mem[w]   = {29'd0, inv, 1'b1, cyc};
    mem[w+1] = 32'd0;
    mem[w+2] = target[31:0];
    mem[w+3] = target[63:32];
    mem[w+4] = 32'd0;
    mem[w+5] = 32'd0;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    n_cmd = 0; n_done = 0; n_abort = 0;
  endtask

  task automatic ring(input bit load, input logic [AW-1:0] p, input bit c);
    @(negedge clk);
    db_ring = 1'b1; db_load = load; db_ptr = p; db_cycle = c;
    @(negedge clk);
    db_ring = 1'b0; db_load = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (st_busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1", "busy after reset", st_busy, 0);
    chk_eq("R1", "cmd_valid after reset", cmd_valid, 0);
    chk_eq("R1", "mem_req_valid after reset", mem_req_valid, 0);
    chk_eq("R1", "irqs after reset", {irq_done, irq_abort}, 0);
    chk_eq("R1", "ptr after reset", st_ptr, 0);
    chk_eq("R1", "cycle after reset", st_cycle, 0);
  endtask

  task automatic t_basic();
    put_data(0, 1, 1, 0, 32'd100, 64'h1_0000_0003, 64'h2_0000_0001);
    put_data(24, 1, 0, 0, 32'd7, 64'h11, 64'h22);
    put_data(48, 0, 0, 0, 32'd1, 64'h0, 64'h0);
    clear_counts();
    ring(1, 32'd0, 1);
    wait_idle();
    chk_eq("R4", "basic cmd count", n_cmd, 2);
    chk_eq("R4", "cmd0 src", lg_src[0], 64'h1_0000_0003);
    chk_eq("R4", "cmd0 dst", lg_dst[0], 64'h2_0000_0001);
    chk_eq("R4", "cmd0 len", lg_len[0], 100);
    chk_eq("R3", "cmd1 fields", {lg_src[1][31:0], lg_dst[1][31:0], lg_len[1]},
           {32'h11, 32'h22, 32'd7});
    chk_eq("R6", "done irq only on enabled element", n_done, 1);
    chk_eq("R7", "no abort on cycle stop", n_abort, 0);
    chk_eq("R5", "ptr parked on stale element", st_ptr, 48);
    chk_eq("R2", "loaded cycle", st_cycle, 1);
  endtask

  task automatic t_resume();
    put_data(48, 1, 1, 0, 32'd5, 64'h33, 64'h44);
    put_data(72, 0, 0, 0, 32'd1, 64'h0, 64'h0);
    clear_counts();
    ring(0, 32'd200, 0);
    wait_idle();
    chk_eq("R7", "resume refetches stopped element", n_cmd, 1);
    chk_eq("R7", "resumed len", lg_len[0], 5);
    chk_eq("R2", "resume keeps cycle", st_cycle, 1);
    chk_eq("R5", "ptr after resume", st_ptr, 72);
    chk_eq("R6", "done irq on resumed element", n_done, 1);
  endtask

  task automatic t_link_invert();
    put_link(72, 1, 1, 64'd128);
    put_data(128, 0, 0, 1, 32'd9, 64'h55, 64'h66);
    put_data(152, 1, 0, 0, 32'd1, 64'h0, 64'h0);
    clear_counts();
    ring(0, 32'd0, 0);
    wait_idle();
    chk_eq("R8", "link issues no cmd, target runs", n_cmd, 1);
    chk_eq("R8", "target element len", lg_len[0], 9);
    chk_eq("R8", "cycle inverted", st_cycle, 0);
    chk_eq("R8", "ptr after inverted link", st_ptr, 152);
    chk_eq("R6", "remote enable raises done", n_done, 1);
  endtask

  task automatic t_link_plain();
    put_link(176, 0, 0, 64'd200);
    put_data(200, 0, 0, 0, 32'd11, 64'hAAAA_BBBB_0000_0001, 64'h2);
    put_data(224, 1, 0, 0, 32'd4, 64'h0, 64'h0);
    clear_counts();
    ring(1, 32'd176, 0);
    wait_idle();
    chk_eq("R8", "plain link cmd count", n_cmd, 1);
    chk_eq("R8", "plain link src", lg_src[0], 64'hAAAA_BBBB_0000_0001);
    chk_eq("R8", "plain link keeps cycle", st_cycle, 0);
    chk_eq("R8", "ptr after plain link", st_ptr, 224);
    chk_eq("R6", "no done without enables", n_done, 0);
  endtask

  task automatic t_zero_len();
    put_data(0, 1, 1, 0, 32'd0, 64'h1, 64'h2);
    clear_counts();
    ring(1, 32'd0, 1);
    wait_idle();
    chk_eq("R9", "zero length issues no cmd", n_cmd, 0);
    chk_eq("R9", "abort pulse count", n_abort, 1);
    chk_eq("R9", "no done on abort", n_done, 0);
    chk_eq("R9", "ptr on faulty element", st_ptr, 0);
    chk_eq("R9", "idle after abort", st_busy, 0);
  endtask

  task automatic t_read_err();
    put_data(0, 1, 0, 0, 32'd3, 64'h7, 64'h8);
    put_data(24, 1, 0, 0, 32'd5, 64'h9, 64'hA);
    err_addr = 32'd32;
    err_on   = 1'b1;
    clear_counts();
    ring(1, 32'd0, 1);
    wait_idle();
    err_on = 1'b0;
    chk_eq("R10", "cmd before failing element", n_cmd, 1);
    chk_eq("R10", "first cmd len", lg_len[0], 3);
    chk_eq("R10", "abort pulse count", n_abort, 1);
    chk_eq("R10", "ptr on failing element", st_ptr, 24);
  endtask

  task automatic t_busy_ring();
    put_data(0, 1, 0, 1, 32'd50, 64'h100, 64'h200);
    put_data(24, 1, 0, 0, 32'd60, 64'h300, 64'h400);
    put_data(48, 0, 0, 0, 32'd1, 64'h0, 64'h0);
    put_data(128, 0, 0, 0, 32'd77, 64'h0, 64'h0);
    clear_counts();
    ring(1, 32'd0, 1);
    repeat (6) @(negedge clk);
    chk_eq("R11", "busy during run", st_busy, 1);
    ring(1, 32'd128, 0);
    wait_idle();
    chk_eq("R11", "cmd count with busy ring", n_cmd, 2);
    chk_eq("R11", "lens with busy ring", {lg_len[0], lg_len[1]}, {32'd50, 32'd60});
    chk_eq("R11", "ptr unaffected", st_ptr, 48);
    chk_eq("R11", "cycle unaffected", st_cycle, 1);
  endtask

  initial begin
    db_ring = 0; db_load = 0; db_ptr = '0; db_cycle = 0;
    err_on = 0; err_addr = '0;
    n_cmd = 0; n_done = 0; n_abort = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_resume();
    t_link_invert();
    t_link_plain();
    t_zero_len();
    t_read_err();
    t_busy_ring();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule